// File: doc/BRIEF.md
# Dual Capture/Compare Timer Channel

This block is one channel of a 16-bit timer. It holds a free-running up-counter and two general registers. At run time each register can act as an output compare register or as an input capture register. In compare mode the register is checked against the counter. On a match it raises its event flag and can drive, clear or toggle its own compare pin. In capture mode it watches its own external input. On the selected edge it takes a snapshot of the counter and raises the same event flag.

Software reaches the channel over a small 16-bit register bus. The bus has byte enables, and read data is registered. A flag is cleared by reading it as one and then writing zero to it. A standby input holds the whole channel in its reset state for as long as it is high.

Top module: `capcmp_timer`

## Requirements
- R1: After reset, and after standby, the counter reads 0x0000 and both general registers read 0xFFFF. Every mode field is 000, meaning compare with no pin action. Both flags and both compare pins are 0.
- R2: The counter increments once per cycle while the run bit (control bit 0) is 1 and holds while it is 0. It wraps from 0xFFFF to 0x0000. A bus write to the counter takes priority over counting.
- R3: In a compare mode, a register whose value equals the counter while the counter runs sets its flag in the next cycle. Register A uses status bit 0 and register B uses status bit 1. This also happens with mode 000.
- R4: On a compare match the pin action follows the mode field: 000 leaves the pin unchanged, 001 drives it to 0, 010 drives it to 1 and 011 toggles it.
- R5: In capture mode the register copies the counter and sets its flag. Mode 100 captures on a rising edge, 101 on a falling edge, and 110 or 111 on either edge. The input passes through two synchronising flops, so the capture lands on the third rising clock edge after the input changes. In a compare mode, edges on the input have no effect.
- R6: In a single-edge capture mode, an edge of the opposite polarity changes neither the register nor the flag.
- R7: Writes honour the byte enables. Enable bit 0 selects data bits 7:0 and enable bit 1 selects bits 15:8.
- R8: Writing 0 to a status bit clears that flag only if the last status read returned it as 1 and no status write has happened since that read. Writing 1 leaves the flag unchanged.
- R9: A flag set event in the same cycle as a valid clear leaves the flag set.
- R10: If a capture and a bus write hit the same general register in one cycle, the register takes the captured counter value.
- R11: While standby is high, bus writes are ignored and the channel is held in its R1 state.
- R12: The word address map is: 0 control (bit 0 run, bits 6:4 mode A, bits 10:8 mode B), 1 status, 2 counter, 3 register A, 4 register B. Any other address reads 0. Read data appears, with its valid strobe, one cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Holds the channel in its reset state |
| busAddr | input | 3 | Word address |
| busWrEn | input | 1 | Write request |
| busRdEn | input | 1 | Read request |
| busByteEn | input | 2 | Byte lane enables for writes |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Registered read data |
| busRdValid | output | 1 | Read data valid, one cycle after busRdEn |
| capIn | input | 2 | Capture inputs; bit 0 for register A, bit 1 for register B |
| cmpPin | output | 2 | Compare pins; bit 0 for register A, bit 1 for register B |

## Verification
On every cycle, the embedded properties check the counter wrap, the flag that follows a compare match, the captured value that follows a capture strobe, the clearing effect of standby, and the one-cycle read latency. Some behaviours appear only in the bench's ordered scenarios. These are the read-then-write protocol for clearing flags, the byte-lane merges, the per-mode pin actions and edge polarities, and the two same-cycle conflicts, which the bench times to the synchroniser latency.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  localparam int NUM_GR = 2;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_STS = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CNT = 3'd2;
  localparam int                ADDR_GR0 = 3;

  // Mode field of a control word: bit 2 selects capture.
  typedef enum logic [2:0] {
    IO_NONE      = 3'b000,
    IO_LOW       = 3'b001,
    IO_HIGH      = 3'b010,
    IO_TOGGLE    = 3'b011,
    IO_CAP_RISE  = 3'b100,
    IO_CAP_FALL  = 3'b101,
    IO_CAP_BOTH  = 3'b110,
    IO_CAP_BOTH2 = 3'b111
  } ioMode_t;

  // Least significant bit of a register's mode field in the control word.
  function automatic int ioLsb(input int idx);
    return 4 + 4 * idx;
  endfunction

  typedef struct packed {
    logic                   standby;
    logic                   run;
    ioMode_t [NUM_GR-1:0]   ioMode;
    logic [NUM_GR-1:0]      cap;
    logic                   cntWr;
    logic [NUM_GR-1:0]      grWr;
    logic [1:0]             byteEn;
    logic [NUM_GR-1:0]      flagClr;
  } dpStrobe_t;
endpackage

// File: rtl/capcmp_edge.sv
module capcmp_edge (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic syncA, syncB, prev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      prev  <= 1'b0;
    end else begin
      syncA <= din;
      syncB <= syncA;
      prev  <= syncB;
    end
  end

  assign rise = syncB & ~prev;
  assign fall = ~syncB & prev;
endmodule

// File: rtl/capcmp_ctrl.sv
module capcmp_ctrl
  import capcmp_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int BE_W = CNT_W / 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          standby,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic                          busWrEn,
  input  logic                          busRdEn,
  input  logic [BE_W-1:0]               busByteEn,
  input  logic [CNT_W-1:0]              busWrData,
  input  logic [NUM_GR-1:0]             capIn,
  input  logic [CNT_W-1:0]              cnt,
  input  logic [NUM_GR-1:0][CNT_W-1:0]  gr,
  input  logic [NUM_GR-1:0]             flags,
  output dpStrobe_t                     strb,
  output logic [CNT_W-1:0]              busRdData,
  output logic                          busRdValid
);
  logic                 runEn;
  ioMode_t [NUM_GR-1:0] ioMode;
  logic [NUM_GR-1:0]    armed;
  logic [NUM_GR-1:0]    rise, fall, capEv, grWr, flagClr;
  logic                 wrOk, ctlWr, stsWr;
  logic [CNT_W-1:0]     rdNext;

  assign wrOk  = busWrEn && !standby;
  assign ctlWr = wrOk && (busAddr == ADDR_CTL);
  assign stsWr = wrOk && (busAddr == ADDR_STS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      runEn <= 1'b0;
    else if (standby)               runEn <= 1'b0;
    else if (ctlWr && busByteEn[0]) runEn <= busWrData[0];
  end

  for (genvar i = 0; i < NUM_GR; i++) begin : g_chan
    localparam int LSB  = ioLsb(i);
    localparam int LANE = LSB / 8;

    capcmp_edge u_edge (
      .clk  (clk),
      .rstN (rstN),
      .din  (capIn[i]),
      .rise (rise[i]),
      .fall (fall[i])
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                         ioMode[i] <= IO_NONE;
      else if (standby)                  ioMode[i] <= IO_NONE;
      else if (ctlWr && busByteEn[LANE]) ioMode[i] <= ioMode_t'(busWrData[LSB +: 3]);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                     armed[i] <= 1'b0;
      else if (standby || stsWr)                     armed[i] <= 1'b0;
      else if (busRdEn && busAddr == ADDR_STS)       armed[i] <= flags[i];
    end

    always_comb begin
      unique case (ioMode[i])
        IO_CAP_RISE:              capEv[i] = rise[i];
        IO_CAP_FALL:              capEv[i] = fall[i];
        IO_CAP_BOTH, IO_CAP_BOTH2: capEv[i] = rise[i] | fall[i];
        default:                  capEv[i] = 1'b0;
      endcase
    end

    assign grWr[i]    = wrOk && (busAddr == ADDR_W'(ADDR_GR0 + i));
    assign flagClr[i] = stsWr && busByteEn[0] && armed[i] && !busWrData[i];
  end

  always_comb begin
    strb         = '0;
    strb.standby = standby;
    strb.run     = runEn;
    strb.ioMode  = ioMode;
    strb.cap     = standby ? '0 : capEv;
    strb.cntWr   = wrOk && (busAddr == ADDR_CNT);
    strb.grWr    = grWr;
    strb.byteEn  = busByteEn;
    strb.flagClr = flagClr;
  end

  always_comb begin
    rdNext = '0;
    if (busAddr == ADDR_CTL) begin
      rdNext[0] = runEn;
      for (int i = 0; i < NUM_GR; i++) rdNext[ioLsb(i) +: 3] = ioMode[i];
    end else if (busAddr == ADDR_STS) begin
      rdNext[NUM_GR-1:0] = flags;
    end else if (busAddr == ADDR_CNT) begin
      rdNext = cnt;
    end else begin
      for (int i = 0; i < NUM_GR; i++)
        if (busAddr == ADDR_W'(ADDR_GR0 + i)) rdNext = gr[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdData  <= '0;
      busRdValid <= 1'b0;
    end else begin
      busRdValid <= busRdEn;
      if (busRdEn) busRdData <= rdNext;
    end
  end

  // R12
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |=> busRdValid);

  // R11
  standby_ctl_chk: assert property (@(posedge clk) disable iff (!rstN)
    standby |=> (!runEn && ioMode[0] == IO_NONE && ioMode[1] == IO_NONE));
endmodule

// File: rtl/capcmp_datapath.sv
module capcmp_datapath
  import capcmp_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int BE_W = CNT_W / 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpStrobe_t                     strb,
  input  logic [CNT_W-1:0]              wrData,
  output logic [CNT_W-1:0]              cnt,
  output logic [NUM_GR-1:0][CNT_W-1:0]  gr,
  output logic [NUM_GR-1:0]             flags,
  output logic [NUM_GR-1:0]             cmpPin
);
  function automatic logic [CNT_W-1:0] mergeBytes(input logic [CNT_W-1:0] oldVal,
                                                  input logic [CNT_W-1:0] newVal,
                                                  input logic [1:0]       be);
    logic [CNT_W-1:0] res;
    res = oldVal;
    for (int b = 0; b < BE_W; b++)
      if (be[b]) res[b*8 +: 8] = newVal[b*8 +: 8];
    return res;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= '0;
    else if (strb.standby) cnt <= '0;
    else if (strb.cntWr) cnt <= mergeBytes(cnt, wrData, strb.byteEn);
    else if (strb.run)   cnt <= cnt + CNT_W'(1);
  end

  logic [NUM_GR-1:0] match;

  for (genvar i = 0; i < NUM_GR; i++) begin : g_reg
    logic isCap;
    assign isCap    = strb.ioMode[i][2];
    assign match[i] = !isCap && strb.run && (cnt == gr[i]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               gr[i] <= '1;
      else if (strb.standby)   gr[i] <= '1;
      else if (strb.cap[i])    gr[i] <= cnt;
      else if (strb.grWr[i])   gr[i] <= mergeBytes(gr[i], wrData, strb.byteEn);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                        flags[i] <= 1'b0;
      else if (strb.standby)            flags[i] <= 1'b0;
      else if (match[i] || strb.cap[i]) flags[i] <= 1'b1;
      else if (strb.flagClr[i])         flags[i] <= 1'b0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             cmpPin[i] <= 1'b0;
      else if (strb.standby) cmpPin[i] <= 1'b0;
      else if (match[i]) begin
        unique case (strb.ioMode[i])
          IO_LOW:    cmpPin[i] <= 1'b0;
          IO_HIGH:   cmpPin[i] <= 1'b1;
          IO_TOGGLE: cmpPin[i] <= ~cmpPin[i];
          default:   cmpPin[i] <= cmpPin[i];
        endcase
      end
    end

    // R3
    match_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
      (match[i] && !strb.standby) |=> flags[i]);

    // R9
    set_beats_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.flagClr[i] && strb.cap[i] && !strb.standby) |=> flags[i]);

    // R10
    cap_value_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.cap[i] && !strb.standby) |=> (gr[i] == $past(cnt)));

    // R1
    standby_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.standby |=> (gr[i] == '1 && !flags[i] && !cmpPin[i]));
  end

  // R2
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.cntWr && !strb.standby && cnt == '1) |=> (cnt == '0));
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
  import capcmp_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int BE_W = CNT_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              standby,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [BE_W-1:0]   busByteEn,
  input  logic [CNT_W-1:0]  busWrData,
  output logic [CNT_W-1:0]  busRdData,
  output logic              busRdValid,
  input  logic [NUM_GR-1:0] capIn,
  output logic [NUM_GR-1:0] cmpPin
);
  dpStrobe_t                    strb;
  logic [CNT_W-1:0]             cnt;
  logic [NUM_GR-1:0][CNT_W-1:0] gr;
  logic [NUM_GR-1:0]            flags;

  capcmp_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .standby    (standby),
    .busAddr    (busAddr),
    .busWrEn    (busWrEn),
    .busRdEn    (busRdEn),
    .busByteEn  (busByteEn),
    .busWrData  (busWrData),
    .capIn      (capIn),
    .cnt        (cnt),
    .gr         (gr),
    .flags      (flags),
    .strb       (strb),
    .busRdData  (busRdData),
    .busRdValid (busRdValid)
  );

  capcmp_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (busWrData),
    .cnt    (cnt),
    .gr     (gr),
    .flags  (flags),
    .cmpPin (cmpPin)
  );
endmodule

// File: tb/capcmp_timer_bench.sv
module capcmp_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        standby = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [1:0]  busByteEn = 2'b11;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic        busRdValid;
  logic [1:0]  capIn = 2'b00;
  logic [1:0]  cmpPin;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [2:0]  addr;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sbQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  capcmp_timer u_capcmp_timer (
    .clk(clk), .rstN(rstN), .standby(standby),
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busByteEn(busByteEn), .busWrData(busWrData),
    .busRdData(busRdData), .busRdValid(busRdValid),
    .capIn(capIn), .cmpPin(cmpPin)
  );

  // Monitor: pops expected read items as read data becomes valid.
  always @(negedge clk) begin
    if (busRdValid) begin
      if (sbQ.size() == 0) begin
        errors++;
        $display("FAIL monitor: unexpected read data %h expected none", busRdData);
      end else begin
        item_t it;
        it = sbQ.pop_front();
        checks++;
        if (busRdData !== it.exp) begin
          errors++;
          $display("FAIL %s addr %0d: actual %h expected %h", it.tag, it.addr, busRdData, it.exp);
        end
      end
    end
  end

  task automatic busWrite(input logic [2:0] a, input logic [15:0] d, input logic [1:0] be = 2'b11);
    @(negedge clk);
    busAddr = a; busWrData = d; busByteEn = be; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busByteEn = 2'b11;
  endtask

  task automatic expectRead(input logic [2:0] a, input logic [15:0] e, input string tag);
    item_t it;
    @(negedge clk);
    it.addr = a; it.exp = e; it.tag = tag;
    sbQ.push_back(it);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic checkPins(input logic [1:0] e, input string tag);
    checks++;
    if (cmpPin !== e) begin
      errors++;
      $display("FAIL %s pins: actual %b expected %b", tag, cmpPin, e);
    end
  endtask

  // Changes a capture input, then presents a write in the cycle the capture lands.
  task automatic capWithWrite(input int idx, input logic lvl, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    capIn[idx] = lvl;
    @(negedge clk);
    @(negedge clk);
    busAddr = a; busWrData = d; busByteEn = 2'b11; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic setCap(input int idx, input logic lvl);
    @(negedge clk);
    capIn[idx] = lvl;
    idle(5);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);

    // R1 and R12: reset values and address map
    checkPins(2'b00, "R1");
    expectRead(3'd0, 16'h0000, "R1 ctl");
    expectRead(3'd1, 16'h0000, "R1 sts");
    expectRead(3'd2, 16'h0000, "R1 cnt");
    expectRead(3'd3, 16'hFFFF, "R1 grA");
    expectRead(3'd4, 16'hFFFF, "R1 grB");
    expectRead(3'd5, 16'h0000, "R12 unmapped");

    // R2: wrap over two counting cycles; R3/R4: mode 000 match at 0xFFFF
    busWrite(3'd2, 16'hFFFE);
    busWrite(3'd0, 16'h0001);
    busWrite(3'd0, 16'h0000);
    expectRead(3'd2, 16'h0000, "R2 wrap");
    idle(3);
    expectRead(3'd2, 16'h0000, "R2 hold");
    expectRead(3'd1, 16'h0003, "R3 flags on match");
    checkPins(2'b00, "R4 none");

    // R8: flag clear protocol
    busWrite(3'd1, 16'h0003);
    busWrite(3'd1, 16'h0000);
    expectRead(3'd1, 16'h0003, "R8 no clear without read");
    busWrite(3'd1, 16'h0002);
    expectRead(3'd1, 16'h0002, "R8 clear A only");
    busWrite(3'd1, 16'h0000);
    expectRead(3'd1, 16'h0000, "R8 clear B");

    // R7: byte lanes
    busWrite(3'd4, 16'hABCD);
    busWrite(3'd4, 16'h1200, 2'b10);
    expectRead(3'd4, 16'h12CD, "R7 high byte");
    busWrite(3'd4, 16'h0034, 2'b01);
    expectRead(3'd4, 16'h1234, "R7 low byte");

    // R4: drive high on A, toggle on B
    busWrite(3'd2, 16'h0010);
    busWrite(3'd3, 16'h0014);
    busWrite(3'd4, 16'h0018);
    busWrite(3'd0, 16'h0321);
    idle(12);
    busWrite(3'd0, 16'h0000);
    checkPins(2'b11, "R4 high/toggle");
    expectRead(3'd1, 16'h0003, "R3 compare flags");
    busWrite(3'd1, 16'h0000);
    // R4: drive low on A, toggle back on B
    busWrite(3'd2, 16'h0010);
    busWrite(3'd0, 16'h0311);
    idle(12);
    busWrite(3'd0, 16'h0000);
    checkPins(2'b00, "R4 low/toggle");
    expectRead(3'd1, 16'h0003, "R3 flags again");
    busWrite(3'd1, 16'h0000);
    expectRead(3'd1, 16'h0000, "R8 cleared");

    // R5/R6: capture modes with the counter stopped
    busWrite(3'd0, 16'h0540);
    busWrite(3'd2, 16'h4321);
    setCap(0, 1'b1);
    expectRead(3'd3, 16'h4321, "R5 rise capture A");
    setCap(1, 1'b1);
    expectRead(3'd4, 16'h0018, "R6 rising ignored B");
    expectRead(3'd1, 16'h0001, "R6 flag B untouched");
    busWrite(3'd2, 16'h5555);
    setCap(0, 1'b0);
    expectRead(3'd3, 16'h4321, "R6 falling ignored A");
    setCap(1, 1'b0);
    expectRead(3'd4, 16'h5555, "R5 fall capture B");
    expectRead(3'd1, 16'h0003, "R5 flags");
    busWrite(3'd0, 16'h0760);
    busWrite(3'd2, 16'h0777);
    setCap(0, 1'b1);
    expectRead(3'd3, 16'h0777, "R5 both rise A");
    busWrite(3'd2, 16'h0888);
    setCap(1, 1'b1);
    expectRead(3'd4, 16'h0888, "R5 mode 111 rise B");
    busWrite(3'd2, 16'h0999);
    setCap(0, 1'b0);
    expectRead(3'd3, 16'h0999, "R5 both fall A");
    busWrite(3'd0, 16'h0000);
    busWrite(3'd2, 16'h0AAA);
    setCap(0, 1'b1);
    expectRead(3'd3, 16'h0999, "R5 compare mode ignores edge");

    // R10: capture beats a same-cycle write
    busWrite(3'd0, 16'h0060);
    busWrite(3'd2, 16'h0ABC);
    capWithWrite(0, 1'b0, 3'd3, 16'h5555);
    idle(1);
    expectRead(3'd3, 16'h0ABC, "R10 capture priority");

    // R9: set beats a same-cycle clear
    expectRead(3'd1, 16'h0003, "R9 pre flags");
    busWrite(3'd1, 16'h0000);
    expectRead(3'd1, 16'h0000, "R9 cleared");
    busWrite(3'd0, 16'h0660);
    setCap(1, 1'b0);
    expectRead(3'd1, 16'h0002, "R9 flag B set");
    capWithWrite(1, 1'b1, 3'd1, 16'h0000);
    idle(1);
    expectRead(3'd1, 16'h0002, "R9 set wins");

    // R11: standby
    busWrite(3'd0, 16'h0321);
    idle(4);
    @(negedge clk);
    standby = 1'b1;
    busWrite(3'd3, 16'h1111);
    idle(2);
    standby = 1'b0;
    idle(1);
    checkPins(2'b00, "R11 pins");
    expectRead(3'd3, 16'hFFFF, "R11 grA");
    expectRead(3'd4, 16'hFFFF, "R11 grB");
    expectRead(3'd0, 16'h0000, "R11 ctl");
    expectRead(3'd1, 16'h0000, "R11 sts");
    expectRead(3'd2, 16'h0000, "R11 cnt");

    idle(3);
    if (sbQ.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sbQ.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule